// File: doc/BRIEF.md
# Urgency-Gated Two-Thread Switch Controller

This block decides when an in-order pipeline shared by two hardware threads should swap its foreground thread. It keeps a 3-bit urgency level for each thread and updates it from per-thread event pulses: last-level cache misses and refills, and interrupts aimed at the thread that is not running. A cycle counter bounds how long the foreground thread may run before it must yield.

A swap can be triggered by quantum expiry, a software switch hint, a spin-wait or invalidation hint, or entry into low-power execution. A cache miss on the foreground thread triggers a swap only when the waiting thread's urgency is strictly higher than the foreground thread's urgency after the miss has lowered it. To swap, the controller raises `flush_req` and holds it until the flush logic answers with a one-cycle `flush_done`. Triggers that arrive while it waits are dropped. When `flush_done` is seen, the active thread id flips and the quantum counter restarts. The request/acknowledge pair is the only handshake. All other pins are plain single-cycle event or status lines.

Top module: `thread_switch_ctrl`

## Requirements
- R1: After reset, `active_thread` is 0, both urgency outputs read 5, and `flush_req` is 0.
- R2: A miss pulse for a thread lowers its urgency by one and leaves it at 0 if it is already 0. A miss on the waiting thread never requests a swap.
- R3: A refill pulse raises a thread's urgency by one only while it is below 5. At 5, 6 or 7 a refill leaves it unchanged. A miss and a refill for the same thread in the same cycle leave its urgency unchanged.
- R4: After `QUANTUM_CYCLES` cycles of uninterrupted foreground running, `flush_req` rises, and the outgoing thread's urgency reads 7 in the same cycle.
- R5: An interrupt pulse for the waiting thread sets its urgency to 6. An interrupt pulse for the foreground thread changes nothing.
- R6: A miss on the foreground thread raises `flush_req` in the next cycle only if the waiting thread's urgency is strictly greater than the foreground thread's lowered urgency. Equal levels do not switch.
- R7: Each of `sw_hint`, `spin_hint` and `lowpwr_evt` on its own raises `flush_req` in the next cycle.
- R8: While `flush_req` is high and `flush_done` is low, `flush_req` stays high, `active_thread` holds, and further triggers are ignored. Urgency updates continue.
- R9: A `flush_done` pulse while `flush_req` is high flips `active_thread`, drops `flush_req` in the next cycle, and restarts the quantum count from zero. A `flush_done` pulse with no pending request has no effect.
- R10: When several events arrive in one cycle, the urgency updates are applied first, and the miss-switch comparison uses the updated levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_evt | input | 2 | Per-thread cache-miss pulse (bit = thread id) |
| refill_evt | input | 2 | Per-thread cache-refill pulse |
| irq_evt | input | 2 | Per-thread asynchronous interrupt pulse |
| sw_hint | input | 1 | Software-directed switch request |
| spin_hint | input | 1 | Spin-wait or speculation-invalidation switch request |
| lowpwr_evt | input | 1 | Low-power execution entry, requests a switch |
| flush_done | input | 1 | Pipeline flush complete acknowledge |
| flush_req | output | 1 | Pipeline flush request, held until acknowledged |
| active_thread | output | 1 | Foreground thread id |
| urg_t0 | output | 3 | Urgency level of thread 0 |
| urg_t1 | output | 3 | Urgency level of thread 1 |

## Verification
The miss-switch comparison is tested with a waiting thread at a higher level, at an equal level, and at a lower level that an interrupt raises in the same cycle. Together these separate a strict comparison from a non-strict one, and comparing updated levels from comparing stale ones. Urgency is walked down to the floor and back up to the refill cap, and refills are applied at level 7. This tells a saturating refill from a plain increment. The quantum is measured both from reset and from the end of a flush, with stray triggers and acknowledges placed inside and outside the busy window.

// File: rtl/thread_sw_pkg.sv
package thread_sw_pkg;
  localparam int URG_W      = 3;
  localparam int N_THR      = 2;
  localparam int REFILL_CAP = 5;
  localparam int URG_QEXP   = 7;
  localparam int URG_IRQ    = 6;
  localparam int URG_RESET  = 5;

  typedef logic [URG_W-1:0] urg_t;

  typedef enum logic {SW_RUN = 1'b0, SW_FLUSH = 1'b1} sw_state_e;
endpackage

// File: rtl/urgency_unit.sv
module urgency_unit
  import thread_sw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss,
  input  logic refill,
  input  logic set_irq,
  input  logic set_quantum,
  output urg_t urg_q,
  output urg_t urg_nx
);
  // fixed-value events override counting; miss and refill together cancel
  always_comb begin
    urg_nx = urg_q;
    if (set_irq) begin
      urg_nx = urg_t'(URG_IRQ);
    end else if (set_quantum) begin
      urg_nx = urg_t'(URG_QEXP);
    end else if (miss && !refill) begin
      if (urg_q != '0) urg_nx = urg_q - urg_t'(1);
    end else if (refill && !miss) begin
      if (urg_q < urg_t'(REFILL_CAP)) urg_nx = urg_q + urg_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) urg_q <= urg_t'(URG_RESET);
    else        urg_q <= urg_nx;
  end
endmodule

// File: rtl/quantum_timer.sv
module quantum_timer #(
  parameter int QUANTUM_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic reload,
  output logic expire
);
  localparam int QW = (QUANTUM_CYCLES > 1) ? $clog2(QUANTUM_CYCLES) : 1;
  localparam logic [QW-1:0] LAST = QW'(QUANTUM_CYCLES - 1);

  logic [QW-1:0] qcnt;

  assign expire = run && (qcnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)               qcnt <= '0;
    else if (reload)          qcnt <= '0;
    else if (run && !expire)  qcnt <= qcnt + QW'(1);
  end
endmodule

// File: rtl/switch_fsm.sv
module switch_fsm
  import thread_sw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  input  logic flush_done,
  output logic busy,
  output logic active,
  output logic complete
);
  sw_state_e state;

  assign busy     = (state == SW_FLUSH);
  assign complete = busy && flush_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SW_RUN;
      active <= 1'b0;
    end else begin
      case (state)
        SW_RUN:   if (trigger) state <= SW_FLUSH;
        SW_FLUSH: if (flush_done) begin
                    state  <= SW_RUN;
                    active <= ~active;
                  end
        default:  state <= SW_RUN;
      endcase
    end
  end
endmodule

// File: rtl/thread_switch_ctrl.sv
module thread_switch_ctrl
  import thread_sw_pkg::*;
#(
  parameter int QUANTUM_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] miss_evt,
  input  logic [1:0] refill_evt,
  input  logic [1:0] irq_evt,
  input  logic       sw_hint,
  input  logic       spin_hint,
  input  logic       lowpwr_evt,
  input  logic       flush_done,
  output logic       flush_req,
  output logic       active_thread,
  output logic [2:0] urg_t0,
  output logic [2:0] urg_t1
);
  urg_t urg_q  [N_THR];
  urg_t urg_nx [N_THR];
  logic busy, complete, quantum_hit, miss_switch, trigger, fg;

  assign fg = active_thread;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    urgency_unit u_urg (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss       (miss_evt[t]),
      .refill     (refill_evt[t]),
      .set_irq    (irq_evt[t] && (fg != 1'(t))),
      .set_quantum(quantum_hit && (fg == 1'(t))),
      .urg_q      (urg_q[t]),
      .urg_nx     (urg_nx[t])
    );
  end

  quantum_timer #(.QUANTUM_CYCLES(QUANTUM_CYCLES)) u_qt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!busy),
    .reload(complete),
    .expire(quantum_hit)
  );

  // decision on post-update levels
  assign miss_switch = miss_evt[fg] && (urg_nx[~fg] > urg_nx[fg]);
  assign trigger     = !busy &&
                       (quantum_hit || sw_hint || spin_hint || lowpwr_evt || miss_switch);

  switch_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigger   (trigger),
    .flush_done(flush_done),
    .busy      (busy),
    .active    (active_thread),
    .complete  (complete)
  );

  assign flush_req = busy;
  assign urg_t0    = urg_q[0];
  assign urg_t1    = urg_q[1];
endmodule

// File: rtl/thread_switch_chk.sv
module thread_switch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] miss_evt,
  input logic [1:0] refill_evt,
  input logic [1:0] irq_evt,
  input logic       quantum_hit,
  input logic       flush_done,
  input logic       flush_req,
  input logic       active_thread,
  input logic [2:0] urg_t0,
  input logic [2:0] urg_t1
);
  logic [2:0] u [2];
  assign u[0] = urg_t0;
  assign u[1] = urg_t1;

  for (genvar t = 0; t < 2; t++) begin : g_chk
    logic fixed_set;
    assign fixed_set = (irq_evt[t] && active_thread != 1'(t)) ||
                       (quantum_hit && active_thread == 1'(t));

    assert_miss_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_evt[t] && !refill_evt[t] && !fixed_set && u[t] != 3'd0)
        |=> (u[t] == $past(u[t]) - 3'd1));

    assert_refill_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_evt[t] && !miss_evt[t] && !fixed_set && u[t] >= 3'd5)
        |=> $stable(u[t]));

    assert_irq_bg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_evt[t] && active_thread != 1'(t)) |=> (u[t] == 3'd6));
  end

  assert_quantum_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    quantum_hit |=> (flush_req && u[active_thread] == 3'd7));

  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_done) |=> (flush_req && $stable(active_thread)));

  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && flush_done) |=> (!flush_req && active_thread != $past(active_thread)));
endmodule

bind thread_switch_ctrl thread_switch_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_evt     (miss_evt),
  .refill_evt   (refill_evt),
  .irq_evt      (irq_evt),
  .quantum_hit  (quantum_hit),
  .flush_done   (flush_done),
  .flush_req    (flush_req),
  .active_thread(active_thread),
  .urg_t0       (urg_t0),
  .urg_t1       (urg_t1)
);

// File: tb/sim_thread_switch_ctrl.sv
module sim_thread_switch_ctrl;
  localparam int QC = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] miss_evt = '0, refill_evt = '0, irq_evt = '0;
  logic sw_hint = 1'b0, spin_hint = 1'b0, lowpwr_evt = 1'b0, flush_done = 1'b0;
  logic flush_req, active_thread;
  logic [2:0] urg_t0, urg_t1;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  thread_switch_ctrl #(.QUANTUM_CYCLES(QC)) u0 (
    .clk(clk), .rst_n(rst_n), .miss_evt(miss_evt), .refill_evt(refill_evt),
    .irq_evt(irq_evt), .sw_hint(sw_hint), .spin_hint(spin_hint),
    .lowpwr_evt(lowpwr_evt), .flush_done(flush_done), .flush_req(flush_req),
    .active_thread(active_thread), .urg_t0(urg_t0), .urg_t1(urg_t1)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // drive one-cycle pulses, then clear
  task automatic pulse(input logic [1:0] m, input logic [1:0] r, input logic [1:0] i,
                       input logic sw, input logic sp, input logic lp, input logic fd);
    miss_evt = m; refill_evt = r; irq_evt = i;
    sw_hint = sw; spin_hint = sp; lowpwr_evt = lp; flush_done = fd;
    step();
    miss_evt = '0; refill_evt = '0; irq_evt = '0;
    sw_hint = 1'b0; spin_hint = 1'b0; lowpwr_evt = 1'b0; flush_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 active", active_thread, 0);
    check("R1 urg_t0", urg_t0, 5);
    check("R1 urg_t1", urg_t1, 5);
    check("R1 flush_req", flush_req, 0);
  endtask

  task automatic t_miss_floor();
    do_reset();
    for (int k = 4; k >= -1; k--) begin
      pulse(2'b10, 2'b00, 2'b00, 0, 0, 0, 0);
      check("R2 bg miss decrement", urg_t1, (k < 0) ? 0 : k);
      check("R2 bg miss no switch", flush_req, 0);
    end
  endtask

  task automatic t_refill_cap();
    do_reset();
    pulse(2'b10, 2'b00, 2'b00, 0, 0, 0, 0);
    pulse(2'b10, 2'b00, 2'b00, 0, 0, 0, 0);
    check("R2 setup", urg_t1, 3);
    pulse(2'b00, 2'b10, 2'b00, 0, 0, 0, 0);
    check("R3 refill up", urg_t1, 4);
    pulse(2'b10, 2'b10, 2'b00, 0, 0, 0, 0);
    check("R3 miss+refill cancel", urg_t1, 4);
    pulse(2'b00, 2'b10, 2'b00, 0, 0, 0, 0);
    check("R3 refill to cap", urg_t1, 5);
    pulse(2'b00, 2'b11, 2'b00, 0, 0, 0, 0);
    check("R3 refill at cap t1", urg_t1, 5);
    check("R3 refill at cap t0", urg_t0, 5);
  endtask

  task automatic t_quantum();
    do_reset();
    for (int k = 0; k < QC - 1; k++) step();
    check("R4 no early expiry", flush_req, 0);
    step();
    check("R4 expiry flush", flush_req, 1);
    check("R4 outgoing urgency 7", urg_t0, 7);
    pulse(2'b00, 2'b01, 2'b00, 0, 0, 0, 0);
    check("R3 refill at 7 holds", urg_t0, 7);
    pulse(2'b00, 2'b00, 2'b00, 1, 0, 0, 0);
    check("R8 busy holds req", flush_req, 1);
    check("R8 busy holds active", active_thread, 0);
    pulse(2'b00, 2'b00, 2'b00, 0, 0, 0, 1);
    check("R9 active flips", active_thread, 1);
    check("R9 req drops", flush_req, 0);
    for (int k = 0; k < QC - 1; k++) step();
    check("R9 quantum reloaded, no early expiry", flush_req, 0);
    step();
    check("R9 quantum reloaded expiry", flush_req, 1);
    check("R4 thread1 urgency 7", urg_t1, 7);
  endtask

  task automatic t_miss_switch();
    do_reset();
    pulse(2'b01, 2'b00, 2'b00, 0, 0, 0, 0);
    check("R6 higher bg switches", flush_req, 1);
    check("R2 fg urgency lowered", urg_t0, 4);
    pulse(2'b01, 2'b00, 2'b00, 0, 0, 0, 0);
    check("R8 miss during busy lowers", urg_t0, 3);
    check("R8 active held", active_thread, 0);
    pulse(2'b00, 2'b00, 2'b00, 0, 0, 0, 1);
    check("R9 active flips", active_thread, 1);
    pulse(2'b00, 2'b01, 2'b00, 0, 0, 0, 0);
    check("R3 bg refill", urg_t0, 4);
    pulse(2'b10, 2'b00, 2'b00, 0, 0, 0, 0);
    check("R6 equal levels no switch", flush_req, 0);
    check("R6 fg lowered to 4", urg_t1, 4);
    pulse(2'b10, 2'b00, 2'b00, 0, 0, 0, 0);
    check("R6 bg higher after miss switches", flush_req, 1);
  endtask

  task automatic t_irq();
    do_reset();
    pulse(2'b00, 2'b00, 2'b01, 0, 0, 0, 0);
    check("R5 fg irq ignored", urg_t0, 5);
    check("R5 fg irq no switch", flush_req, 0);
    pulse(2'b00, 2'b00, 2'b10, 0, 0, 0, 0);
    check("R5 bg irq sets 6", urg_t1, 6);
    do_reset();
    pulse(2'b10, 2'b00, 2'b00, 0, 0, 0, 0);
    pulse(2'b10, 2'b00, 2'b00, 0, 0, 0, 0);
    pulse(2'b01, 2'b00, 2'b00, 0, 0, 0, 0);
    check("R6 lower bg no switch", flush_req, 0);
    pulse(2'b01, 2'b00, 2'b10, 0, 0, 0, 0);
    check("R10 irq raises bg before compare", flush_req, 1);
    check("R10 bg urgency 6", urg_t1, 6);
    check("R10 fg urgency 3", urg_t0, 3);
  endtask

  task automatic t_hints();
    do_reset();
    pulse(2'b00, 2'b00, 2'b00, 0, 0, 0, 1);
    check("R9 stray done no flip", active_thread, 0);
    check("R9 stray done no req", flush_req, 0);
    pulse(2'b00, 2'b00, 2'b00, 1, 0, 0, 0);
    check("R7 sw hint", flush_req, 1);
    pulse(2'b00, 2'b00, 2'b00, 0, 0, 0, 1);
    check("R9 flip to 1", active_thread, 1);
    pulse(2'b00, 2'b00, 2'b00, 0, 1, 0, 0);
    check("R7 spin hint", flush_req, 1);
    pulse(2'b00, 2'b00, 2'b00, 0, 0, 0, 1);
    check("R9 flip to 0", active_thread, 0);
    pulse(2'b00, 2'b00, 2'b00, 0, 0, 1, 0);
    check("R7 low power", flush_req, 1);
    pulse(2'b00, 2'b00, 2'b00, 0, 0, 0, 1);
    check("R9 flip to 1 again", active_thread, 1);
    check("R9 req cleared", flush_req, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_miss_floor();
    t_refill_cap();
    t_quantum();
    t_miss_switch();
    t_irq();
    t_hints();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule